// File: doc/BRIEF.md
# Three-Channel Timer Command and Byte Access Port

This block is the byte-wide register front end for a bank of three counting channels. Software writes a command byte to one address of a four-address window. The command either sets a channel's configuration or takes a snapshot of its count. The other three addresses are per-channel data ports. Writes to a data port build a 16-bit initial count and issue a one-cycle load strobe. Reads from a data port return count bytes, from the live value or from a frozen snapshot.

The counting engines sit outside this block. They take the load strobes, initial counts and mode settings from it, and they return their running counts on `cnt_live`. The block decodes the command fields and keeps separate low/high byte sequencing for writes and for reads on each channel. It also enforces the rule that a channel holding an unread snapshot ignores new commands.

Top module: `tmr_cmd_port`

## Requirements
- R1: Command byte fields: bits 7-6 pick the channel (00, 01, 10), bits 5-4 pick the access kind (00 snapshot, 01 low byte only, 10 high byte only, 11 low then high), bits 3-1 the counting mode and bit 0 the BCD flag. A non-snapshot command updates that channel's `ch_acc`, `ch_mode` and `ch_bcd` by the next cycle. Reset gives access 11, mode 0, BCD 0, zero initial counts, no strobes and `bus_rdata` zero.
- R2: Offsets 0, 1 and 2 are the data ports of channels 0, 1 and 2, and offset 3 is the command port. Read data appears on `bus_rdata` one cycle after `bus_re`, and a read of offset 3 returns zero.
- R3: In low-byte-only access, a data write sets the initial count to {8'h00, byte} and pulses the channel's `load_stb` for one cycle.
- R4: In high-byte-only access, a data write sets the initial count to {byte, 8'h00} and pulses `load_stb`.
- R5: In low-then-high access, the first data write only holds the low byte and does not pulse `load_stb`. The second write sets the count to {second, first} and pulses `load_stb`.
- R6: Reads without a snapshot return live count bytes: the low byte on every read in low-only access, the high byte on every read in high-only access, and the low byte then the high byte alternately in low-then-high access.
- R7: A snapshot command (access 00) copies the channel's `cnt_live` in the cycle of the write. Reads return the copy, following the channel's access kind, however the live count moves. The command's mode and BCD bits change nothing.
- R8: While a channel holds an unread snapshot, every command aimed at it is ignored, including further snapshots. Other channels keep accepting commands. The hold ends once the snapshot has been read out: one read in single-byte access, two in low-then-high access.
- R9: Bits 7-4 equal to 1101 form a group snapshot, with bit 3 picking channel 2, bit 2 channel 1 and bit 1 channel 0. Each picked channel is captured unless it already holds a snapshot. Other commands with bits 7-6 = 11 change nothing.
- R10: A non-snapshot command to a channel restarts both its write and its read byte sequences at the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Byte write strobe |
| bus_re | input | 1 | Byte read strobe |
| bus_addr | input | AW (2) | Offset in the four-address window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| cnt_live | input | NCH*16 (48) | Running counts from the channels, channel 0 in the low bits |
| load_stb | output | NCH (3) | One-cycle load pulse per channel |
| init_cnt | output | NCH*16 (48) | Initial count per channel |
| ch_acc | output | NCH*2 (6) | Access kind per channel |
| ch_mode | output | NCH*3 (9) | Counting mode per channel |
| ch_bcd | output | NCH (3) | BCD flag per channel |

## Verification
The hardest state to reach is several channels holding snapshots at once, each at a different point of its read-out. A snapshot of another channel, or a group snapshot, then arrives while one of them is still pending. The stimulus captures channels individually and in groups, moves `cnt_live` right after each capture, and interleaves rejected and accepted commands between partial read-outs. Only the copied values and unchanged settings visible at the ports can then show that each channel's hold was kept and released on its own.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LOW  = 2'b01,
    ACC_HIGH = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } cmd_t;
endpackage

// File: rtl/tcp_cmd_dec.sv
module tcp_cmd_dec
  import tcp_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic                  cmd_we,
  input  logic [BYTE_W-1:0]     cmd_byte,
  output logic [NCH-1:0]        set_req,
  output logic [NCH-1:0]        snap_req,
  output acc_e                  acc,
  output logic [MODE_W-1:0]     mode,
  output logic                  bcd
);
  cmd_t c;
  logic grp;

  assign c    = cmd_t'(cmd_byte);
  assign acc  = c.acc;
  assign mode = c.mode;
  assign bcd  = c.bcd;
  // group snapshot: channel field all ones with low-only access code
  assign grp  = (c.sel == 2'b11) && (c.acc == ACC_LOW);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign set_req[i]  = cmd_we && (c.sel == 2'(i)) && (c.acc != ACC_SNAP);
    assign snap_req[i] = cmd_we && (((c.sel == 2'(i)) && (c.acc == ACC_SNAP)) ||
                                    (grp && cmd_byte[i+1]));
  end
endmodule

// File: rtl/tcp_chan.sv
module tcp_chan
  import tcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_req,
  input  logic              snap_req,
  input  acc_e              cfg_acc,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_bcd,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              rd_stb,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic              load_stb,
  output logic [CNT_W-1:0]  init_cnt,
  output acc_e              acc_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              bcd_q,
  output logic [BYTE_W-1:0] rd_byte
);
  logic              wtog, rtog, pend;
  logic [BYTE_W-1:0] lo_hold;
  logic [CNT_W-1:0]  snap, src;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_stb <= 1'b0;
      init_cnt <= '0;
      acc_q    <= ACC_WORD;
      mode_q   <= '0;
      bcd_q    <= 1'b0;
      wtog     <= 1'b0;
      rtog     <= 1'b0;
      pend     <= 1'b0;
      lo_hold  <= '0;
      snap     <= '0;
    end else begin
      load_stb <= 1'b0;
      if (wr_stb) begin
        case (acc_q)
          ACC_LOW: begin
            init_cnt <= {{BYTE_W{1'b0}}, wr_byte};
            load_stb <= 1'b1;
          end
          ACC_HIGH: begin
            init_cnt <= {wr_byte, {BYTE_W{1'b0}}};
            load_stb <= 1'b1;
          end
          ACC_WORD: begin
            if (!wtog) begin
              lo_hold <= wr_byte;
              wtog    <= 1'b1;
            end else begin
              init_cnt <= {wr_byte, lo_hold};
              load_stb <= 1'b1;
              wtog     <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (rd_stb) begin
        if (acc_q == ACC_WORD) rtog <= ~rtog;
        if (pend && ((acc_q != ACC_WORD) || rtog)) pend <= 1'b0;
      end
      // configuration comes last so its sequence restart wins
      if (set_req && !pend) begin
        acc_q  <= cfg_acc;
        mode_q <= cfg_mode;
        bcd_q  <= cfg_bcd;
        wtog   <= 1'b0;
        rtog   <= 1'b0;
      end
      if (snap_req && !pend) begin
        snap <= cnt_live;
        pend <= 1'b1;
      end
    end
  end

  assign src = pend ? snap : cnt_live;

  always_comb begin
    case (acc_q)
      ACC_HIGH: rd_byte = src[CNT_W-1:BYTE_W];
      ACC_WORD: rd_byte = rtog ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
      default:  rd_byte = src[BYTE_W-1:0];
    endcase
  end

  a_r5_no_early_load: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && acc_q == ACC_WORD && !wtog) |=> !load_stb);
  a_r3_low_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (load_stb && acc_q == ACC_LOW) |-> (init_cnt[CNT_W-1:BYTE_W] == '0));
  a_r4_high_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (load_stb && acc_q == ACC_HIGH) |-> (init_cnt[BYTE_W-1:0] == '0));
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (pend && set_req) |=> ($stable(mode_q) && $stable(acc_q) && $stable(bcd_q)));
  a_r7_snap_held: assert property (@(posedge clk) disable iff (rst)
    (pend && !rd_stb) |=> (pend && $stable(snap)));
endmodule

// File: rtl/tmr_cmd_port.sv
module tmr_cmd_port
  import tcp_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_we,
  input  logic                    bus_re,
  input  logic [AW-1:0]           bus_addr,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  input  logic [NCH*CNT_W-1:0]    cnt_live,
  output logic [NCH-1:0]          load_stb,
  output logic [NCH*CNT_W-1:0]    init_cnt,
  output logic [NCH*2-1:0]        ch_acc,
  output logic [NCH*MODE_W-1:0]   ch_mode,
  output logic [NCH-1:0]          ch_bcd
);
  localparam logic [AW-1:0] CMD_ADDR = AW'(NCH);

  logic [NCH-1:0]    set_req, snap_req;
  acc_e              cfg_acc;
  logic [MODE_W-1:0] cfg_mode;
  logic              cfg_bcd;
  logic [BYTE_W-1:0] rd_b [NCH];
  logic [BYTE_W-1:0] rd_sel;

  tcp_cmd_dec #(.NCH(NCH)) u_dec (
    .cmd_we   (bus_we && bus_addr == CMD_ADDR),
    .cmd_byte (bus_wdata),
    .set_req  (set_req),
    .snap_req (snap_req),
    .acc      (cfg_acc),
    .mode     (cfg_mode),
    .bcd      (cfg_bcd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    acc_e acc_i;
    tcp_chan u_ch (
      .clk      (clk),
      .rst      (rst),
      .set_req  (set_req[i]),
      .snap_req (snap_req[i]),
      .cfg_acc  (cfg_acc),
      .cfg_mode (cfg_mode),
      .cfg_bcd  (cfg_bcd),
      .wr_stb   (bus_we && bus_addr == AW'(i)),
      .wr_byte  (bus_wdata),
      .rd_stb   (bus_re && bus_addr == AW'(i)),
      .cnt_live (cnt_live[i*CNT_W +: CNT_W]),
      .load_stb (load_stb[i]),
      .init_cnt (init_cnt[i*CNT_W +: CNT_W]),
      .acc_q    (acc_i),
      .mode_q   (ch_mode[i*MODE_W +: MODE_W]),
      .bcd_q    (ch_bcd[i]),
      .rd_byte  (rd_b[i])
    );
    assign ch_acc[i*2 +: 2] = acc_i;
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == AW'(i)) rd_sel = rd_b[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_sel;
  end

  a_r2_cmd_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == CMD_ADDR) |=> (bus_rdata == '0));
endmodule

// File: tb/tmr_cmd_port_test.sv
module tmr_cmd_port_test;
  localparam int CLK_P = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_INIT = 2'd2, OP_MODE = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [7:0]  data;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{OP_WR,   2'd3, 8'h12, 16'h0000},  // R1 ch0 low-only mode1
    '{OP_MODE, 2'd0, 8'h00, 16'h0012},  // R1
    '{OP_WR,   2'd0, 8'hA5, 16'h0001},  // R3 strobe ch0
    '{OP_INIT, 2'd0, 8'h00, 16'h00A5},  // R3
    '{OP_WR,   2'd3, 8'h64, 16'h0000},  // R1 ch1 high-only mode2
    '{OP_WR,   2'd1, 8'h3C, 16'h0002},  // R4
    '{OP_INIT, 2'd1, 8'h00, 16'h3C00},  // R4
    '{OP_WR,   2'd3, 8'hB7, 16'h0000},  // R1 ch2 word mode3 bcd
    '{OP_MODE, 2'd2, 8'h00, 16'h0037},  // R1
    '{OP_WR,   2'd2, 8'h34, 16'h0000},  // R5 no strobe yet
    '{OP_INIT, 2'd2, 8'h00, 16'h0000},  // R5
    '{OP_WR,   2'd2, 8'h12, 16'h0004},  // R5 strobe
    '{OP_INIT, 2'd2, 8'h00, 16'h1234},  // R5
    '{OP_RD,   2'd2, 8'h00, 16'h000F},  // R6 low
    '{OP_RD,   2'd2, 8'h00, 16'h005A},  // R6 high
    '{OP_RD,   2'd0, 8'h00, 16'h0034},  // R6 low-only
    '{OP_RD,   2'd0, 8'h00, 16'h0034},  // R6
    '{OP_RD,   2'd1, 8'h00, 16'h00AB},  // R6 high-only
    '{OP_RD,   2'd3, 8'h00, 16'h0000}   // R2
  };

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic [15:0] c0 = 16'h1234, c1 = 16'hABCD, c2 = 16'h5A0F;
  logic [47:0] cnt_live;
  logic [2:0]  load_stb, ch_bcd;
  logic [47:0] init_cnt;
  logic [5:0]  ch_acc;
  logic [8:0]  ch_mode;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  assign cnt_live = {c2, c1, c0};
  always #(CLK_P/2) clk = ~clk;

  tmr_cmd_port uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_live(cnt_live),
    .load_stb(load_stb), .init_cnt(init_cnt), .ch_acc(ch_acc),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [15:0] cfg(input int a);
    return {10'd0, ch_acc[2*a +: 2], ch_mode[3*a +: 3], ch_bcd[a]};
  endfunction

  task automatic rdchk(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    chk(req, {8'h00, d}, {8'h00, e});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset strobe", {13'd0, load_stb}, 16'h0000);
    chk("R1 reset init0", init_cnt[15:0], 16'h0000);
    chk("R1 reset cfg0", cfg(0), 16'h0030);
    chk("R1 reset cfg2", cfg(2), 16'h0030);
    chk("R1 reset rdata", {8'h00, bus_rdata}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: begin
          wr(VEC[i].addr, VEC[i].data);
          chk($sformatf("vec%0d R1/R3/R4/R5 strobe", i), {13'd0, load_stb}, VEC[i].exp);
        end
        OP_RD: rdchk($sformatf("vec%0d R2/R6 read", i), VEC[i].addr, VEC[i].exp[7:0]);
        OP_INIT: chk($sformatf("vec%0d R3/R4/R5 init", i),
                     init_cnt[16*VEC[i].addr +: 16], VEC[i].exp);
        default: chk($sformatf("vec%0d R1 cfg", i), cfg(int'(VEC[i].addr)), VEC[i].exp);
      endcase
    end

    // R8: snapshot on ch2 freezes its commands only
    wr(2'd3, 8'h80);
    c2 = 16'h7777;
    wr(2'd3, 8'h92);
    chk("R8 ch2 cmd ignored", cfg(2), 16'h0037);
    wr(2'd3, 8'h52);
    chk("R8 ch1 still accepts", cfg(1), 16'h0012);
    rdchk("R7 ch2 snap low", 2'd2, 8'h0F);
    wr(2'd3, 8'h92);
    chk("R8 frozen mid read-out", cfg(2), 16'h0037);
    rdchk("R7 ch2 snap high", 2'd2, 8'h5A);
    rdchk("R8 ch2 live after release", 2'd2, 8'h77);
    wr(2'd3, 8'h92);
    chk("R8 ch2 cmd accepted", cfg(2), 16'h0012);

    // R7: snapshot ignores mode bits, low-only access
    wr(2'd3, 8'h0E);
    c0 = 16'h9999;
    chk("R7 mode bits ignored", cfg(0), 16'h0012);
    rdchk("R7 ch0 snap", 2'd0, 8'h34);
    rdchk("R7 ch0 live after", 2'd0, 8'h99);

    // R9: group snapshot of ch0 and ch1 only
    wr(2'd3, 8'h30);
    chk("R1 ch0 word mode0", cfg(0), 16'h0030);
    c0 = 16'h1111; c1 = 16'h2222; c2 = 16'h7777;
    wr(2'd3, 8'hD6);
    c0 = 16'hEEEE; c1 = 16'hEEEE; c2 = 16'hEEEE;
    rdchk("R9 ch0 snap low", 2'd0, 8'h11);
    rdchk("R9 ch0 snap high", 2'd0, 8'h11);
    rdchk("R9 ch1 snap", 2'd1, 8'h22);
    rdchk("R9 ch2 not picked", 2'd2, 8'hEE);
    rdchk("R9 ch0 live", 2'd0, 8'hEE);
    rdchk("R9 ch0 live hi", 2'd0, 8'hEE);
    rdchk("R9 ch1 live", 2'd1, 8'hEE);

    // R9: other 11xx commands change nothing
    wr(2'd3, 8'hE4);
    wr(2'd3, 8'hC0);
    chk("R9 ignored cmd cfg0", cfg(0), 16'h0030);
    chk("R9 ignored cmd cfg1", cfg(1), 16'h0012);
    c0 = 16'h4321;
    rdchk("R9 no stray snap lo", 2'd0, 8'h21);
    rdchk("R9 no stray snap hi", 2'd0, 8'h43);

    // R8/R9: group snapshot skips a channel already pending
    wr(2'd3, 8'h00);
    c0 = 16'h5555;
    wr(2'd3, 8'hD2);
    rdchk("R9 pending kept lo", 2'd0, 8'h21);
    rdchk("R9 pending kept hi", 2'd0, 8'h43);
    rdchk("R9 live after", 2'd0, 8'h55);
    rdchk("R9 live after hi", 2'd0, 8'h55);

    // R10: command restarts write and read sequences
    wr(2'd0, 8'hAA);
    chk("R10 first byte no strobe", {13'd0, load_stb}, 16'h0000);
    wr(2'd3, 8'h30);
    wr(2'd0, 8'hBB);
    chk("R10 restart no strobe", {13'd0, load_stb}, 16'h0000);
    wr(2'd0, 8'hCC);
    chk("R10 strobe on second", {13'd0, load_stb}, 16'h0001);
    chk("R10 init", init_cnt[15:0], 16'hCCBB);
    @(negedge clk);
    chk("R3 strobe one cycle", {13'd0, load_stb}, 16'h0000);
    c0 = 16'h1357;
    rdchk("R10 read lo", 2'd0, 8'h57);
    wr(2'd3, 8'h30);
    rdchk("R10 read restart lo", 2'd0, 8'h57);
    rdchk("R10 read hi", 2'd0, 8'h13);

    summary();
  end
endmodule